// File: doc/BRIEF.md
# Boost Converter Protection Supervisor

This block sits between the analog comparators of a single-string LED boost controller and its switch driver. It receives one digital flag per comparator: output feedback above its over-voltage level, output feedback near zero, switch current above the cycle limit, switch current above the hard limit, LED current sense below its low level, LED current sense above its short level, input under-voltage and over-temperature. It decides whether the power switch may run, whether the current pulse must end early, whether the output must be clamped, and whether the soft-start reference must be discharged. It also drives the fault indicator.

The faults fall into two classes. A latching fault stops switching and discharges the reference until enable is taken low and high again, or until the power reset. A retry fault stops switching only while its flag is present. Every latching fault has its own qualification rule. A millisecond tick input times the slow faults, and a strobe that marks the start of each switching period counts the diode-short cycles.

Top module: `prot_supervisor`

## Requirements
- R1: With enable high and no retry fault, if `ovp_near_zero` stays high through more than DOPEN_MS ticks, the block latches. It latches on tick DOPEN_MS+1. If the flag is held for DOPEN_MS ticks or fewer, it does not latch.
- R2: The block latches when `isns_hard` is seen high in DSHORT_CYC switching periods in a row. Each period is closed by `cycle_strb`. A period closed without the flag resets the count to zero.
- R3: While switching is allowed, `clamp_req` follows `ovp_over` in the same cycle.
- R4: The block latches when `ovp_over` is held through more than OVP_MS ticks. It latches on tick OVP_MS+1.
- R5: The block latches when `ifb_low` is held together with `ovp_over` or with `isns_limit` through more than IFBS_MS ticks. `ifb_low` by itself never latches.
- R6: `ifb_high` latches the block at the next clock edge, with no timer.
- R7: `uvlo_low` and `over_temp` drop `sw_en` and release the fault output in the same cycle. Operation comes back by itself when the flag clears, and neither flag latches.
- R8: While latched, `ref_discharge` is 1 and `sw_en` is 0.
- R9: A latch stays set after its cause has gone. Only enable low, or the reset, clears it. `sw_en` is 0 whenever enable is low.
- R10: `fault_pulldown` is 1 (indicator pulled low) in normal operation. It is 0 (released) while latched or while a retry fault is present.
- R11: Each qualification timer restarts from zero when its condition drops, even for a single cycle.
- R12: `pulse_kill` goes to 1 the cycle after `isns_limit`. It stays at 1 until the clock edge of the next `cycle_strb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low power reset |
| enable | input | 1 | device enable |
| ms_tick | input | 1 | one-cycle pulse per millisecond |
| cycle_strb | input | 1 | start of a switching period |
| ovp_over | input | 1 | output feedback above over-voltage level |
| ovp_near_zero | input | 1 | output feedback below the open-diode level |
| isns_limit | input | 1 | switch current above cycle limit |
| isns_hard | input | 1 | switch current above hard limit |
| ifb_low | input | 1 | LED sense below low level |
| ifb_high | input | 1 | LED sense above short level |
| uvlo_low | input | 1 | input under-voltage |
| over_temp | input | 1 | junction over-temperature |
| sw_en | output | 1 | power switch allowed to run |
| pulse_kill | output | 1 | end the current on-pulse |
| clamp_req | output | 1 | output clamp request |
| ref_discharge | output | 1 | discharge soft-start reference |
| fault_pulldown | output | 1 | 1 pulls the indicator low, 0 releases it |

## Verification
The hardest conditions to reach are the exact edges of the timers. A timer must latch on tick N+1 and not on tick N, and it must restart after a short dropout. The bench sweeps every hold length from zero ticks to two ticks past the limit for each timed fault, and it uses small timer parameters so that the sweep stays short. Between runs it clears the latch with an enable cycle, and it places one-cycle dropouts just before the limit.

// File: rtl/prot_supervisor.sv
module prot_supervisor #(
  parameter int DOPEN_MS   = 80,
  parameter int OVP_MS     = 640,
  parameter int IFBS_MS    = 60,
  parameter int DSHORT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ms_tick,
  input  logic cycle_strb,
  input  logic ovp_over,
  input  logic ovp_near_zero,
  input  logic isns_limit,
  input  logic isns_hard,
  input  logic ifb_low,
  input  logic ifb_high,
  input  logic uvlo_low,
  input  logic over_temp,
  output logic sw_en,
  output logic pulse_kill,
  output logic clamp_req,
  output logic ref_discharge,
  output logic fault_pulldown
);
  localparam int DW = $clog2(DOPEN_MS + 1);
  localparam int OW = $clog2(OVP_MS + 1);
  localparam int IW = $clog2(IFBS_MS + 1);
  localparam int SW = $clog2(DSHORT_CYC + 1);

  logic          latched;
  logic [DW-1:0] dopen_cnt;
  logic [OW-1:0] ovp_cnt;
  logic [IW-1:0] ifbs_cnt;
  logic [SW-1:0] dsh_cnt;
  logic          dsh_seen;

  wire retry_flt = uvlo_low | over_temp;
  wire run_ok    = enable & ~retry_flt & ~latched;
  wire ifbs_cond = ifb_low & (ovp_over | isns_limit);
  wire dsh_hit   = dsh_seen | isns_hard;

  wire dopen_trip = run_ok & ovp_near_zero & ms_tick & (dopen_cnt == DW'(DOPEN_MS));
  wire ovp_trip   = run_ok & ovp_over & ms_tick & (ovp_cnt == OW'(OVP_MS));
  wire ifbs_trip  = run_ok & ifbs_cond & ms_tick & (ifbs_cnt == IW'(IFBS_MS));
  wire dsh_trip   = run_ok & cycle_strb & dsh_hit & (dsh_cnt == SW'(DSHORT_CYC - 1));
  wire any_trip   = (run_ok & ifb_high) | dopen_trip | ovp_trip | ifbs_trip | dsh_trip;

  assign sw_en          = run_ok;
  assign clamp_req      = run_ok & ovp_over;
  assign ref_discharge  = latched;
  assign fault_pulldown = ~(latched | retry_flt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            latched <= 1'b0;
    else if (!enable)      latched <= 1'b0;
    else if (any_trip)     latched <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dopen_cnt <= '0;
      ovp_cnt   <= '0;
      ifbs_cnt  <= '0;
    end else begin
      if (!(run_ok && ovp_near_zero)) dopen_cnt <= '0;
      else if (ms_tick && dopen_cnt != DW'(DOPEN_MS)) dopen_cnt <= dopen_cnt + 1'b1;
      if (!(run_ok && ovp_over)) ovp_cnt <= '0;
      else if (ms_tick && ovp_cnt != OW'(OVP_MS)) ovp_cnt <= ovp_cnt + 1'b1;
      if (!(run_ok && ifbs_cond)) ifbs_cnt <= '0;
      else if (ms_tick && ifbs_cnt != IW'(IFBS_MS)) ifbs_cnt <= ifbs_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsh_cnt  <= '0;
      dsh_seen <= 1'b0;
    end else if (!run_ok) begin
      dsh_cnt  <= '0;
      dsh_seen <= 1'b0;
    end else if (cycle_strb) begin
      dsh_seen <= 1'b0;
      if (!dsh_hit) dsh_cnt <= '0;
      else if (dsh_cnt != SW'(DSHORT_CYC - 1)) dsh_cnt <= dsh_cnt + 1'b1;
    end else if (isns_hard) begin
      dsh_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pulse_kill <= 1'b0;
    else if (!run_ok)    pulse_kill <= 1'b0;
    else if (cycle_strb) pulse_kill <= isns_limit;
    else if (isns_limit) pulse_kill <= 1'b1;
  end

  a_r6_short_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !retry_flt && ifb_high) |=> ref_discharge);
  a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_discharge && enable) |=> ref_discharge);
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ref_discharge);
  a_r8_no_switch_latched: assert property (@(posedge clk) disable iff (!rst_n)
    ref_discharge |-> (!sw_en && !clamp_req));
  a_r12_kill_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_kill && sw_en && !cycle_strb) |=> pulse_kill);
  a_r11_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !ovp_near_zero |=> (dopen_cnt == '0));
  a_r7_retry_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    retry_flt |-> (!sw_en && !fault_pulldown));
endmodule

// File: tb/prot_supervisor_test.sv
module prot_supervisor_test;
  localparam int DO = 4, OV = 6, IS = 3, DS = 3;
  logic clk = 0, rst_n = 0, enable = 0, ms_tick = 0, cycle_strb = 0;
  logic ovp_over = 0, ovp_near_zero = 0, isns_limit = 0, isns_hard = 0;
  logic ifb_low = 0, ifb_high = 0, uvlo_low = 0, over_temp = 0;
  logic sw_en, pulse_kill, clamp_req, ref_discharge, fault_pulldown;
  int checks = 0, fails = 0;
  bit done = 0;

  prot_supervisor #(.DOPEN_MS(DO), .OVP_MS(OV), .IFBS_MS(IS), .DSHORT_CYC(DS)) uut (.*);

  always #4 clk = ~clk;

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1; step(); ms_tick = 0; step();
    end
  endtask

  task automatic strobe(logic hard);
    isns_hard = hard; step(); cycle_strb = 1; step(); cycle_strb = 0; isns_hard = 0; step();
  endtask

  task automatic recycle();
    enable = 0; step(); chk("R9 disabled sw_en", sw_en, 0); enable = 1; step();
  endtask

  initial begin
    step(2);
    chk("R8 reset ref_discharge", ref_discharge, 0);
    chk("R9 reset disabled", sw_en, 0);
    rst_n = 1; enable = 1; step();
    chk("R10 normal pulldown", fault_pulldown, 1);
    chk("R8 normal sw_en", sw_en, 1);

    for (int n = 0; n <= DO + 2; n++) begin
      ovp_near_zero = 1; ticks(n); ovp_near_zero = 0; step(2);
      chk("R1 diode open", ref_discharge, n >= DO + 1);
      if (n >= DO + 1) begin
        chk("R8 sw_en off", sw_en, 0);
        chk("R10 released", fault_pulldown, 0);
        step(3); chk("R9 latch persists", ref_discharge, 1);
      end
      recycle(); chk("R9 cleared", ref_discharge, 0);
    end

    for (int n = 0; n <= OV + 2; n++) begin
      ovp_over = 1; step();
      chk("R3 clamp", clamp_req, n <= OV ? 1'b1 : 1'b1);
      ticks(n); ovp_over = 0; step(2);
      chk("R4 ovp latch", ref_discharge, n >= OV + 1);
      chk("R3 clamp off", clamp_req, 0);
      recycle();
    end

    for (int v = 0; v < 2; v++)
      for (int n = 0; n <= IS + 2; n++) begin
        ifb_low = 1;
        if (v == 0) isns_limit = 1; else ovp_over = 1;
        ticks(n); ifb_low = 0; isns_limit = 0; ovp_over = 0; step(2);
        chk("R5 ifb short", ref_discharge, n >= IS + 1);
        recycle();
      end
    ifb_low = 1; ticks(IS + 3); ifb_low = 0; step(2);
    chk("R5 ifb_low alone", ref_discharge, 0);

    ovp_near_zero = 1; ticks(DO); ovp_near_zero = 0; step();
    ovp_near_zero = 1; ticks(DO); ovp_near_zero = 0; step(2);
    chk("R11 restart diode-open", ref_discharge, 0);
    ovp_over = 1; ticks(OV); ovp_over = 0; step();
    ovp_over = 1; ticks(2); ovp_over = 0; step(2);
    chk("R11 restart ovp", ref_discharge, 0);

    for (int n = 0; n <= DS + 1; n++) begin
      for (int k = 0; k < n; k++) strobe(1);
      step();
      chk("R2 diode short", ref_discharge, n >= DS);
      recycle();
    end
    strobe(1); strobe(1); strobe(0); strobe(1); strobe(1); step();
    chk("R2 broken run", ref_discharge, 0);
    strobe(1); step(); chk("R2 third in row", ref_discharge, 1);
    recycle();

    ifb_high = 1; step(); ifb_high = 0;
    chk("R6 immediate latch", ref_discharge, 1);
    chk("R6 switch off", sw_en, 0);
    recycle();

    uvlo_low = 1; #1;
    chk("R7 uvlo sw off", sw_en, 0);
    chk("R10 uvlo released", fault_pulldown, 0);
    step(); uvlo_low = 0; #1;
    chk("R7 uvlo retry", sw_en, 1);
    chk("R7 uvlo no latch", ref_discharge, 0);
    over_temp = 1; ovp_near_zero = 1; ticks(DO + 3); #1;
    chk("R7 thermal sw off", sw_en, 0);
    over_temp = 0; ovp_near_zero = 0; step(2);
    chk("R7 thermal retry", sw_en, 1);
    chk("R7 thermal no latch", ref_discharge, 0);

    isns_limit = 1; step(); isns_limit = 0;
    chk("R12 kill set", pulse_kill, 1);
    step(3); chk("R12 kill held", pulse_kill, 1);
    cycle_strb = 1; step(); cycle_strb = 0;
    chk("R12 kill cleared", pulse_kill, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule